// File: doc/BRIEF.md
# Shader Flow Sequencer

This block steers instruction flow for one programmable vertex processor. It keeps an 8-bit program counter into a 256-slot instruction store held outside the block. It presents each address on `pc_o` with a valid strobe and reads back the instruction word the store returns for that address in the same cycle. Only the flow-control fields of that word are decoded here. Arithmetic instructions pass through as plain sequential issues to an external vector ALU, which is not part of this block.

Branches and loops are resolved while the program runs, for each vertex. A branch may test a host-loaded boolean register, a host-loaded integer register, or a condition flag that the ALU computes for the current vertex. Subroutine calls and counted loops share a small return stack. A hard cap on the number of executed instructions ends a program that runs too long. The host loads its sixteen boolean and sixteen integer registers between runs, starts the run with a pulse, and waits for the done pulse.

Top module: `shader_seq`

## Requirements
- R1: After reset, busy_o, done_o, issue_valid_o, limit_o and err_o are all low.
- R2: A start_i pulse while idle raises busy_o on the next cycle. It issues from address 0, with issue_valid_o high whenever busy_o is high. The opcode END (bits [17:15] = 7) ends the run: busy_o falls and done_o pulses for exactly one cycle.
- R3: While issue_valid_o is high and ready_i is low, pc_o and issue_valid_o hold and nothing advances.
- R4: Opcodes 0 (ALU) and 1 (no-op) advance the address by one.
- R5: Opcode 2 (branch) jumps to the target in bits [7:0] when its condition holds, and otherwise advances by one. Bits [13:12] pick the condition: 0 always, 1 boolean register, 2 cond_i, 3 integer register nonzero in its low 8 bits. The register index is in bits [11:8]. Bit 14 inverts the condition.
- R6: Opcode 3 (call) pushes the return address (current + 1) and jumps to the target. Opcode 4 (return) pops and jumps to the popped address.
- R7: Opcode 5 (loop begin) reads an iteration count from the low 8 bits of the indexed integer register. A count of zero jumps to the target (the address after the loop end). Any other count pushes a loop entry. Opcode 6 (loop end) goes back to the body start until the count is used up, then pops and advances.
- R8: Calls and loops share a 4-entry stack. A push onto a full stack or a pop from an empty one sets err_o and halts the run, with a done pulse. err_o then stays high while idle.
- R9: The run halts and sets limit_o when the MAX_EXEC-th issued instruction is not END. No more than MAX_EXEC instructions issue.
- R10: Host writes (cfg_we_i; cfg_int_i selects the integer bank, else bit 0 of cfg_data_i goes to a boolean) take effect only while busy_o is low. Writes during a run are ignored.
- R11: A new start clears err_o and limit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| limit_o | output | 1 | Run stopped by the instruction cap |
| err_o | output | 1 | Run stopped by a stack fault |
| pc_o | output | 8 | Address of the instruction being issued |
| issue_valid_o | output | 1 | pc_o is a valid issue |
| ready_i | input | 1 | ALU accepts the issue |
| instr_i | input | INSTR_W | Instruction word at pc_o |
| cond_i | input | 1 | Condition flag computed by the ALU for the vertex |
| cfg_we_i | input | 1 | Host register write strobe |
| cfg_int_i | input | 1 | 1 selects the integer bank, 0 the boolean bank |
| cfg_idx_i | input | 4 | Register index |
| cfg_data_i | input | INT_W | Write data |

## Verification
On every cycle the assertions check the issue handshake. They confirm that a stalled address holds, that the valid strobe never appears without busy, and that done is a single pulse taken while idle. They also check that a start enters address 0 with both flags cleared, that stack depth and the executed count stay within bounds, and that error and limit halt the run. Only the bench scenarios can show the actual address order produced by taken and untaken branches, nested calls, zero-count loops and multi-pass loops. The same holds for the stack fault, the cap, and the rule that host writes landing mid-run are discarded.

// File: rtl/shader_seq_pkg.sv
package shader_seq_pkg;
  localparam int PC_W  = 8;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    OP_ALU  = 3'd0,
    OP_NOP  = 3'd1,
    OP_BRA  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_LOOP = 3'd5,
    OP_ENDL = 3'd6,
    OP_END  = 3'd7
  } flow_op_e;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'd0,
    CS_BOOL   = 2'd1,
    CS_COND   = 2'd2,
    CS_INT    = 2'd3
  } cond_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [PC_W-1:0]  addr;
  } stk_ent_t;
endpackage

// File: rtl/shader_seq_cregs.sv
module shader_seq_cregs #(
  parameter int NUM   = 16,
  parameter int INT_W = 16,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lock_i,
  input  logic                      we_i,
  input  logic                      int_sel_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [INT_W-1:0]          data_i,
  output logic [NUM-1:0]            bool_o,
  output logic [NUM-1:0][INT_W-1:0] int_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic hit;
    assign hit = we_i && !lock_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bool_o[g] <= 1'b0;
        int_o[g]  <= '0;
      end else if (hit) begin
        if (int_sel_i) int_o[g]  <= data_i;
        else           bool_o[g] <= data_i[0];
      end
    end
  end
endmodule

// File: rtl/shader_seq_stack.sv
module shader_seq_stack
  import shader_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             upd_i,
  input  stk_ent_t         push_ent_i,
  input  logic [CNT_W-1:0] upd_cnt_i,
  output stk_ent_t         top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o
);
  stk_ent_t         mem_q [DEPTH];
  logic [LVL_W-1:0] lvl_q;
  logic [PTR_W-1:0] top_ptr, wr_ptr;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign level_o = lvl_q;
  assign top_ptr = empty_o ? '0 : PTR_W'(lvl_q - 1'b1);
  assign wr_ptr  = full_o ? '0 : PTR_W'(lvl_q);
  assign top_o   = mem_q[top_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (clr_i) begin
      lvl_q <= '0;
    end else if (push_i && !full_o) begin
      lvl_q <= lvl_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      lvl_q <= lvl_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (push_i && !full_o && wr_ptr == PTR_W'(g)) begin
        mem_q[g] <= push_ent_i;
      end else if (upd_i && !empty_o && top_ptr == PTR_W'(g)) begin
        mem_q[g].cnt <= upd_cnt_i;
      end
    end
  end
endmodule

// File: rtl/shader_seq_next.sv
module shader_seq_next
  import shader_seq_pkg::*;
#(
  parameter int INSTR_W = 18,
  parameter int NUM     = 16,
  parameter int INT_W   = 16
) (
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic [PC_W-1:0]           pc_i,
  input  logic                      cond_i,
  input  logic [NUM-1:0]            bool_i,
  input  logic [NUM-1:0][INT_W-1:0] int_i,
  input  stk_ent_t                  top_i,
  input  logic                      empty_i,
  input  logic                      full_i,
  output logic [PC_W-1:0]           nxt_pc_o,
  output logic                      push_o,
  output logic                      pop_o,
  output logic                      upd_o,
  output stk_ent_t                  push_ent_o,
  output logic [CNT_W-1:0]          upd_cnt_o,
  output logic                      fin_o,
  output logic                      fault_o
);
  flow_op_e         op;
  cond_sel_e        csel;
  logic [3:0]       idx;
  logic [PC_W-1:0]  tgt, pc_inc;
  logic             inv, cond_raw, take;
  logic [CNT_W-1:0] reg_cnt;

  assign op      = flow_op_e'(instr_i[17:15]);
  assign inv     = instr_i[14];
  assign csel    = cond_sel_e'(instr_i[13:12]);
  assign idx     = instr_i[11:8];
  assign tgt     = instr_i[7:0];
  assign pc_inc  = pc_i + 1'b1;
  assign reg_cnt = int_i[idx][CNT_W-1:0];

  always_comb begin
    unique case (csel)
      CS_ALWAYS: cond_raw = 1'b1;
      CS_BOOL:   cond_raw = bool_i[idx];
      CS_COND:   cond_raw = cond_i;
      default:   cond_raw = (reg_cnt != '0);
    endcase
  end
  assign take = cond_raw ^ inv;

  always_comb begin
    nxt_pc_o   = pc_inc;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    upd_o      = 1'b0;
    push_ent_o = '0;
    upd_cnt_o  = '0;
    fin_o      = 1'b0;
    fault_o    = 1'b0;
    unique case (op)
      OP_BRA: if (take) nxt_pc_o = tgt;
      OP_CALL: begin
        if (full_i) fault_o = 1'b1;
        else begin
          push_o     = 1'b1;
          push_ent_o = '{cnt: '0, addr: pc_inc};
          nxt_pc_o   = tgt;
        end
      end
      OP_RET: begin
        if (empty_i) fault_o = 1'b1;
        else begin
          pop_o    = 1'b1;
          nxt_pc_o = top_i.addr;
        end
      end
      OP_LOOP: begin
        if (reg_cnt == '0) nxt_pc_o = tgt;
        else if (full_i) fault_o = 1'b1;
        else begin
          push_o     = 1'b1;
          push_ent_o = '{cnt: reg_cnt, addr: pc_inc};
        end
      end
      OP_ENDL: begin
        if (empty_i) fault_o = 1'b1;
        else if (top_i.cnt > CNT_W'(1)) begin
          upd_o     = 1'b1;
          upd_cnt_o = top_i.cnt - 1'b1;
          nxt_pc_o  = top_i.addr;
        end else begin
          pop_o = 1'b1;
        end
      end
      OP_END: fin_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/shader_seq.sv
module shader_seq
  import shader_seq_pkg::*;
#(
  parameter int INSTR_W   = 18,
  parameter int INT_W     = 16,
  parameter int NUM_CREG  = 16,
  parameter int STK_DEPTH = 4,
  parameter int MAX_EXEC  = 65536,
  localparam int IDX_W  = $clog2(NUM_CREG),
  localparam int EXEC_W = $clog2(MAX_EXEC + 1),
  localparam int LVL_W  = $clog2(STK_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               limit_o,
  output logic               err_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               issue_valid_o,
  input  logic               ready_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               cond_i,
  input  logic               cfg_we_i,
  input  logic               cfg_int_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [INT_W-1:0]   cfg_data_i
);
  logic                           busy_q, done_q, lim_q, err_q;
  logic [PC_W-1:0]                pc_q;
  logic [EXEC_W-1:0]              exec_cnt_q;
  logic [NUM_CREG-1:0]            bool_r;
  logic [NUM_CREG-1:0][INT_W-1:0] int_r;
  stk_ent_t                       top, push_ent;
  logic                           empty, full, push, pop, upd, fin, fault;
  logic [CNT_W-1:0]               upd_cnt;
  logic [PC_W-1:0]                nxt_pc;
  logic [LVL_W-1:0]               stk_level;
  logic                           fire, launch;

  assign fire          = busy_q && ready_i;
  assign launch        = !busy_q && start_i;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign limit_o       = lim_q;
  assign err_o         = err_q;
  assign pc_o          = pc_q;
  assign issue_valid_o = busy_q;

  shader_seq_cregs #(.NUM(NUM_CREG), .INT_W(INT_W)) u_cregs (
    .clk_i, .rst_ni,
    .lock_i    (busy_q),
    .we_i      (cfg_we_i),
    .int_sel_i (cfg_int_i),
    .idx_i     (cfg_idx_i),
    .data_i    (cfg_data_i),
    .bool_o    (bool_r),
    .int_o     (int_r)
  );

  shader_seq_next #(.INSTR_W(INSTR_W), .NUM(NUM_CREG), .INT_W(INT_W)) u_next (
    .instr_i, .pc_i(pc_q), .cond_i,
    .bool_i     (bool_r),
    .int_i      (int_r),
    .top_i      (top),
    .empty_i    (empty),
    .full_i     (full),
    .nxt_pc_o   (nxt_pc),
    .push_o     (push),
    .pop_o      (pop),
    .upd_o      (upd),
    .push_ent_o (push_ent),
    .upd_cnt_o  (upd_cnt),
    .fin_o      (fin),
    .fault_o    (fault)
  );

  shader_seq_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .clr_i      (launch),
    .push_i     (fire && push),
    .pop_i      (fire && pop),
    .upd_i      (fire && upd),
    .push_ent_i (push_ent),
    .upd_cnt_i  (upd_cnt),
    .top_o      (top),
    .empty_o    (empty),
    .full_o     (full),
    .level_o    (stk_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      lim_q      <= 1'b0;
      err_q      <= 1'b0;
      pc_q       <= '0;
      exec_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy_q     <= 1'b1;
        pc_q       <= '0;
        exec_cnt_q <= '0;
        lim_q      <= 1'b0;
        err_q      <= 1'b0;
      end else if (fire) begin
        exec_cnt_q <= exec_cnt_q + 1'b1;
        if (fault) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (exec_cnt_q == EXEC_W'(MAX_EXEC - 1)) begin
          lim_q  <= 1'b1;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pc_q <= nxt_pc;
        end
      end
    end
  end
endmodule

// File: rtl/shader_seq_chk.sv
module shader_seq_chk #(
  parameter int STK_DEPTH = 4,
  parameter int MAX_EXEC  = 65536,
  parameter int LVL_W     = 3,
  parameter int EXEC_W    = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              limit_o,
  input logic              err_o,
  input logic [7:0]        pc_o,
  input logic              issue_valid_o,
  input logic              ready_i,
  input logic [LVL_W-1:0]  level,
  input logic [EXEC_W-1:0] exec_cnt
);
  assert_valid_needs_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> busy_o);
  assert_start_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && pc_o == 8'd0));
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !ready_i) |=> (issue_valid_o && $stable(pc_o)));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !busy_o && !start_i) |=> err_o);
  assert_stack_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= LVL_W'(STK_DEPTH));
  assert_err_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!busy_o && done_o));
  assert_exec_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_cnt <= EXEC_W'(MAX_EXEC));
  assert_limit_halts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(limit_o) |-> (!busy_o && done_o));
  assert_flags_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!err_o && !limit_o));
endmodule

bind shader_seq shader_seq_chk #(
  .STK_DEPTH(STK_DEPTH), .MAX_EXEC(MAX_EXEC), .LVL_W(LVL_W), .EXEC_W(EXEC_W)
) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .limit_o, .err_o,
  .pc_o, .issue_valid_o, .ready_i,
  .level    (stk_level),
  .exec_cnt (exec_cnt_q)
);

// File: tb/shader_seq_test.sv
module shader_seq_test;
  localparam int CLK_P = 10;
  localparam int CAP   = 64;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, ready = 1, cond = 0;
  logic        cfg_we = 0, cfg_int = 0;
  logic [3:0]  cfg_idx = 0;
  logic [15:0] cfg_data = 0;
  logic        busy, done, limit, err, ivalid;
  logic [7:0]  pc;
  logic [17:0] imem [256];
  logic [17:0] instr;
  bit          stall_en = 0;
  int          n_chk = 0, n_err = 0, cyc = 0;
  int          exp_q [$];
  string       cur_req = "R2";

  assign instr = imem[pc];

  shader_seq #(.MAX_EXEC(CAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .limit_o(limit), .err_o(err),
    .pc_o(pc), .issue_valid_o(ivalid), .ready_i(ready),
    .instr_i(instr), .cond_i(cond),
    .cfg_we_i(cfg_we), .cfg_int_i(cfg_int), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input int op, input int cs, input int inv,
                                      input int idx, input int tgt);
    return {op[2:0], inv[0], cs[1:0], idx[3:0], tgt[7:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) imem[i] = mk(7, 0, 0, 0, 0);
  endtask

  task automatic cfg_write(input bit is_int, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_int = is_int; cfg_idx = idx[3:0]; cfg_data = data[15:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic start_prog();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk); #1;
      if (done) seen = 1;
    end
    check(seen, req, seen, 1);
    check(!busy, req, busy, 0);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic run(input string req, input int trace []);
    cur_req = req;
    foreach (trace[i]) exp_q.push_back(trace[i]);
    start_prog();
    wait_done(req);
  endtask

  // monitor: pop expected issue address on each accepted issue
  always begin
    @(negedge clk); #(CLK_P/4);
    if (rst_n && ivalid && ready) begin
      if (exp_q.size() == 0) check(0, {cur_req, " extra issue"}, pc, -1);
      else check(pc == exp_q.pop_front(), cur_req, pc, -2);
    end
  end

  always @(negedge clk) ready <= stall_en ? (cyc % 3 != 0) : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic load_prog_a();
    clear_mem();
    imem[0] = mk(5, 0, 0, 1, 3);   // loop count int[1], skip to 3
    imem[1] = mk(0, 0, 0, 0, 0);
    imem[2] = mk(6, 0, 0, 0, 0);
    imem[3] = mk(2, 1, 0, 2, 6);   // branch on bool[2]
    imem[4] = mk(1, 0, 0, 0, 0);   // no-op
    imem[5] = mk(0, 0, 0, 0, 0);
    imem[6] = mk(7, 0, 0, 0, 0);
  endtask

  task automatic load_prog_c();
    clear_mem();
    imem[0] = mk(3, 0, 0, 0, 4);   // call 4
    imem[1] = mk(2, 2, 0, 0, 3);   // branch on cond_i
    imem[2] = mk(0, 0, 0, 0, 0);
    imem[3] = mk(7, 0, 0, 0, 0);
    imem[4] = mk(0, 0, 0, 0, 0);
    imem[5] = mk(4, 0, 0, 0, 0);   // return
  endtask

  initial begin
    int lim_tr [];
    clear_mem();
    #(CLK_P*2 + 1);
    // R1 reset state
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!ivalid, "R1 valid", ivalid, 0);
    check(!limit && !err, "R1 flags", {limit, err}, 0);
    @(negedge clk); rst_n = 1;

    // R7 three passes, R5 bool branch taken, R2 start/end, R4 sequential
    cfg_write(1, 1, 3);
    cfg_write(0, 2, 1);
    load_prog_a();
    run("R7", '{0, 1, 2, 1, 2, 1, 2, 3, 6});
    check(!err && !limit, "R2 clean end", {err, limit}, 0);

    // R7 zero count skips, R5 branch not taken, R4 no-op advances, R10 idle write lands
    cfg_write(1, 1, 16'h0100);     // low 8 bits zero
    cfg_write(0, 2, 0);
    run("R4", '{0, 3, 4, 5, 6});

    // R6 call/return with R5 cond_i taken and not taken
    load_prog_c();
    cond = 1;
    run("R6", '{0, 4, 5, 1, 3});
    cond = 0;
    run("R5", '{0, 4, 5, 1, 2, 3});

    // R3 stalls do not change the address order
    cfg_write(1, 1, 2);
    load_prog_a();
    stall_en = 1;
    run("R3", '{0, 1, 2, 1, 2, 3, 4, 5, 6});
    stall_en = 0;

    // R8 overflow by unbounded recursion
    clear_mem();
    imem[0] = mk(3, 0, 0, 0, 0);
    run("R8", '{0, 0, 0, 0, 0});
    check(err, "R8 overflow err", err, 1);
    repeat (3) @(negedge clk);
    check(err, "R8 err sticky", err, 1);

    // R11 next start clears err
    load_prog_c();
    cond = 1;
    run("R11", '{0, 4, 5, 1, 3});
    check(!err, "R11 err cleared", err, 0);

    // R8 underflow
    clear_mem();
    imem[0] = mk(4, 0, 0, 0, 0);
    run("R8", '{0});
    check(err, "R8 underflow err", err, 1);

    // R5 integer condition with inversion: int[1]=2 nonzero, inverted -> fall through
    clear_mem();
    imem[0] = mk(2, 3, 1, 1, 2);
    imem[1] = mk(0, 0, 0, 0, 0);
    run("R5", '{0, 1, 2});

    // R9 cap on a tight loop; R10 write during run ignored
    cfg_write(0, 2, 1);
    clear_mem();
    imem[0] = mk(2, 0, 0, 0, 0);
    lim_tr = new[CAP];
    foreach (lim_tr[i]) lim_tr[i] = 0;
    cur_req = "R9";
    foreach (lim_tr[i]) exp_q.push_back(lim_tr[i]);
    start_prog();
    cfg_write(0, 2, 0);
    wait_done("R9");
    check(limit, "R9 limit", limit, 1);

    // R10: bool[2] still 1, branch taken; R11 limit cleared
    load_prog_a();
    run("R10", '{0, 1, 2, 1, 2, 3, 6});
    check(!limit, "R11 limit cleared", limit, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule